// File: doc/BRIEF.md
# Audio Coprocessor I/O Register Page

This block sits between a small audio coprocessor's CPU bus and the devices around it. It decodes the sixteen-byte I/O page at 0xF0–0xFF and places a 64-byte boot ROM over the top of the 64 KiB address space. Mailbox traffic to a host processor runs through four one-way byte ports in each direction. A DSP register file of 128 bytes is reached indirectly: one register holds an index and a second one moves the data. A control register sets the timer enables, clears the inbound mailbox bytes and hides the boot ROM.

The CPU bus is synchronous. Read data is combinational from the address and the current state. Writes take effect at the rising clock edge. Every CPU write is also forwarded to the external backing RAM. The timers, the RAM array and the DSP live outside this block. They are reached only through select strobes, enables and read-data inputs.

Top module: `apuio_regfile`

## Requirements
- R1: After reset the boot ROM is visible, the DSP index is 0x00, all four inbound and all four outbound port bytes are 0x00, and the timer enables are 3'b000.
- R2: CPU reads of 0xF0, 0xF1, 0xFA, 0xFB and 0xFC return 0x00, whatever the RAM read data is.
- R3: A write to 0xF2 stores an 8-bit DSP index, and a read of 0xF2 returns it unchanged. A read of 0xF3 returns `dsp_rdata`, raises `dsp_rd`, and drives `dsp_addr` with the low 7 bits of the index.
- R4: A write to 0xF3 raises `dsp_we`, with `dsp_wdata` equal to the CPU data, only when the stored index is below 0x80. With an index of 0x80 or above, `dsp_we` stays low.
- R5: Reads of 0xF4+k (k = 0..3) return inbound byte k, which the host loads with `host_wr` and `host_sel` = k. CPU writes to 0xF4+k load outbound byte k, visible on `host_out[8k+7:8k]`. A CPU write to a port address does not change what that address reads back.
- R6: A write to 0xF1 loads bits 2:0 into `tmr_en[2:0]` at the clock edge. In the same cycle, `tmr_restart[i]` pulses for every timer i whose bit is 1 and which was disabled before the write.
- R7: In a write to 0xF1, bit 4 set clears inbound bytes 0 and 1, and bit 5 set clears inbound bytes 2 and 3. A clear wins over a host write to the same byte in the same cycle.
- R8: When a write to 0xF1 has bit 7 = 1, the boot ROM is hidden; bit 7 = 0 makes it visible. While it is visible, reads of 0xFFC0+i (i = 0..63) return ((i·29 + 59) mod 256) XOR ((4·i) mod 256). While it is hidden, those addresses return `ram_rdata`.
- R9: Every CPU write drives `ram_we`, with `ram_addr` and `ram_wdata` equal to the bus, I/O addresses included. Reads of 0xF8 and 0xF9 return `ram_rdata`. Writes to 0xFA+i raise `tmr_tgt_we[i]`.
- R10: A read of 0xFD+i returns timer counter i (`tmr_cnt_in[4i+3:4i]`) zero-extended to 8 bits, and raises `tmr_cnt_rd[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| ram_we | output | 1 | Backing RAM write enable |
| ram_addr | output | 16 | Backing RAM address |
| ram_wdata | output | 8 | Backing RAM write data |
| ram_rdata | input | 8 | Backing RAM read data |
| dsp_addr | output | 7 | DSP register index |
| dsp_rd | output | 1 | DSP read strobe |
| dsp_we | output | 1 | DSP write strobe |
| dsp_wdata | output | 8 | DSP write data |
| dsp_rdata | input | 8 | DSP read data |
| host_wr | input | 1 | Host write strobe for the inbound bytes |
| host_sel | input | 2 | Host inbound byte select |
| host_wdata | input | 8 | Host write data |
| host_out | output | 32 | Outbound bytes, byte k at bits 8k+7:8k |
| tmr_en | output | 3 | Timer enables |
| tmr_restart | output | 3 | Timer restart pulses on enable rising |
| tmr_tgt_we | output | 3 | Timer target write strobes |
| tmr_cnt_rd | output | 3 | Timer counter read strobes |
| tmr_cnt_in | input | 12 | Three 4-bit timer counters |

## Verification
The bench issues a clear and a host write to the same inbound byte in one cycle. If the write had priority, the byte would keep the host data. It writes a DSP index of 0x80 or above and then writes through the data window: a missing guard would raise `dsp_we` with a wrapped address. It writes a port address and then reads it back. A design that shared one storage for both directions would echo the CPU value instead of the host byte. It reads the ROM window on both sides of the 0xFFC0 boundary, with the ROM shown, hidden and shown again. A stuck visibility bit or a wrong boundary would return RAM data where the ROM belongs, or the reverse.

// File: rtl/apuio_pkg.sv
// Package: shared constants, the read-source type and the boot ROM function
// for the audio coprocessor I/O register page.
package apuio_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_PORTS = 4;
    localparam int NUM_TMR   = 3;
    localparam int TCNT_W    = 4;
    localparam int ROM_BYTES = 64;
    localparam int DSP_AW    = 7;
    localparam int PIDX_W    = $clog2(NUM_PORTS);
    localparam int TIDX_W    = $clog2(NUM_TMR);
    localparam int ROM_AW    = $clog2(ROM_BYTES);
    localparam int CLR_GRPS  = NUM_PORTS / 2;
    localparam logic [ADDR_W-5:0] IO_PAGE = 12'h00F;

    typedef enum logic [2:0] {
        RS_RAM  = 3'd0,
        RS_ZERO = 3'd1,
        RS_DIDX = 3'd2,
        RS_DDAT = 3'd3,
        RS_PORT = 3'd4,
        RS_TCNT = 3'd5,
        RS_ROM  = 3'd6
    } rd_src_e;

    // Boot ROM byte i: (i*29 + 59) xor (i*4), all modulo 256
    function automatic logic [DATA_W-1:0] rom_byte(input logic [ROM_AW-1:0] idx);
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] m;
        x = {2'b00, idx};
        m = x * 8'd29;
        return (m + 8'h3B) ^ {idx, 2'b00};
    endfunction
endpackage

// File: rtl/apuio_decode.sv
// Address decoder. Classifies a CPU address into a read source and the I/O
// register hits, and gives the sub-index for ports and timers.
// Assumes the I/O page is 0xF0-0xFF and the ROM window is the top 64 bytes.
module apuio_decode
    import apuio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_vis,
    output rd_src_e           rsel,
    output logic              hit_ctl,
    output logic              hit_didx,
    output logic              hit_ddat,
    output logic              hit_port,
    output logic              hit_tgt,
    output logic              hit_tcnt,
    output logic [PIDX_W-1:0] port_idx,
    output logic [TIDX_W-1:0] tgt_idx,
    output logic [TIDX_W-1:0] cnt_idx
);
    logic       io_page;
    logic       rom_hit;
    logic [3:0] lo;

    assign io_page  = (addr[ADDR_W-1:4] == IO_PAGE);
    assign rom_hit  = rom_vis && (addr[ADDR_W-1:ROM_AW] == '1);
    assign lo       = addr[3:0];
    assign port_idx = lo[PIDX_W-1:0];
    assign tgt_idx  = lo[1:0] - 2'd2;
    assign cnt_idx  = lo[1:0] - 2'd1;

    // Purpose: map the address to a read source and register hits
    always_comb begin
        rsel     = RS_RAM;
        hit_ctl  = 1'b0;
        hit_didx = 1'b0;
        hit_ddat = 1'b0;
        hit_port = 1'b0;
        hit_tgt  = 1'b0;
        hit_tcnt = 1'b0;
        if (io_page) begin
            case (lo)
                4'h0:                   rsel = RS_ZERO;
                4'h1: begin             rsel = RS_ZERO; hit_ctl  = 1'b1; end
                4'h2: begin             rsel = RS_DIDX; hit_didx = 1'b1; end
                4'h3: begin             rsel = RS_DDAT; hit_ddat = 1'b1; end
                4'h4, 4'h5, 4'h6, 4'h7: begin rsel = RS_PORT; hit_port = 1'b1; end
                4'hA, 4'hB, 4'hC: begin rsel = RS_ZERO; hit_tgt  = 1'b1; end
                4'hD, 4'hE, 4'hF: begin rsel = RS_TCNT; hit_tcnt = 1'b1; end
                default:                rsel = RS_RAM;
            endcase
        end else if (rom_hit) begin
            rsel = RS_ROM;
        end
    end
endmodule

// File: rtl/apuio_ctl.sv
// Control state: timer enables, boot ROM visibility and the DSP index.
// Assumes ctl_we and idx_we are already qualified with the CPU write strobe.
module apuio_ctl
    import apuio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                idx_we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_TMR-1:0]  tmr_en,
    output logic [NUM_TMR-1:0]  tmr_restart,
    output logic [CLR_GRPS-1:0] clr_grp,
    output logic                rom_vis,
    output logic [DATA_W-1:0]   dsp_idx
);
    logic unused_bits;
    assign unused_bits = ^{wdata[6], wdata[3]};

    assign tmr_restart = {NUM_TMR{ctl_we}} & wdata[NUM_TMR-1:0] & ~tmr_en;
    assign clr_grp     = {CLR_GRPS{ctl_we}} & wdata[5:4];

    // Purpose: hold the timer enables and ROM visibility from control writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en  <= '0;
            rom_vis <= 1'b1;
        end else if (ctl_we) begin
            tmr_en  <= wdata[NUM_TMR-1:0];
            rom_vis <= ~wdata[7];
        end
    end

    // Purpose: hold the indirect DSP index
    always_ff @(posedge clk) begin
        if (!rst_n)      dsp_idx <= '0;
        else if (idx_we) dsp_idx <= wdata;
    end

    assert_tmr_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> tmr_en == $past(wdata[NUM_TMR-1:0]));
    assert_rom_vis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> rom_vis == !$past(wdata[7]));
    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(dsp_idx));
endmodule

// File: rtl/apuio_ports.sv
// Mailbox bank. Inbound bytes are written by the host and read by the CPU.
// Outbound bytes are written by the CPU and seen by the host.
// Assumes the clear groups cover consecutive pairs of inbound bytes.
module apuio_ports
    import apuio_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic [PIDX_W-1:0]             host_sel,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic [CLR_GRPS-1:0]           clr_grp,
    input  logic                          out_we,
    input  logic [PIDX_W-1:0]             out_sel,
    input  logic [DATA_W-1:0]             cpu_wdata,
    output logic [NUM_PORTS*DATA_W-1:0]   in_bytes,
    output logic [NUM_PORTS*DATA_W-1:0]   out_bytes
);
    logic [DATA_W-1:0] in_q  [NUM_PORTS];
    logic [DATA_W-1:0] out_q [NUM_PORTS];

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        // Purpose: inbound byte k, where a clear wins over a host write
        always_ff @(posedge clk) begin
            if (!rst_n)                                      in_q[k] <= '0;
            else if (clr_grp[k/2])                           in_q[k] <= '0;
            else if (host_wr && host_sel == PIDX_W'(k))      in_q[k] <= host_wdata;
        end

        // Purpose: outbound byte k, written by the CPU
        always_ff @(posedge clk) begin
            if (!rst_n)                                      out_q[k] <= '0;
            else if (out_we && out_sel == PIDX_W'(k))        out_q[k] <= cpu_wdata;
        end

        assign in_bytes[k*DATA_W +: DATA_W]  = in_q[k];
        assign out_bytes[k*DATA_W +: DATA_W] = out_q[k];

        assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_grp[k/2] |=> in_q[k] == '0);
        assert_host_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && host_sel == PIDX_W'(k) && !clr_grp[k/2]) |=> in_q[k] == $past(host_wdata));
        assert_out_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_we && out_sel == PIDX_W'(k)) |=> out_q[k] == $past(cpu_wdata));
        assert_in_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!host_wr && clr_grp == '0) |=> $stable(in_q[k]));
    end
endmodule

// File: rtl/apuio_regfile.sv
// Top of the audio coprocessor I/O register page. Connects the decoder, the
// control state and the mailbox bank, muxes the CPU read data, forwards all
// writes to RAM and drives the DSP and timer strobes.
// Assumes external RAM, DSP and timer read data are combinational.
module apuio_regfile
    import apuio_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic                        cpu_rd,
    input  logic                        cpu_wr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        ram_we,
    output logic [ADDR_W-1:0]           ram_addr,
    output logic [DATA_W-1:0]           ram_wdata,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic [DSP_AW-1:0]           dsp_addr,
    output logic                        dsp_rd,
    output logic                        dsp_we,
    output logic [DATA_W-1:0]           dsp_wdata,
    input  logic [DATA_W-1:0]           dsp_rdata,
    input  logic                        host_wr,
    input  logic [PIDX_W-1:0]           host_sel,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic [NUM_PORTS*DATA_W-1:0] host_out,
    output logic [NUM_TMR-1:0]          tmr_en,
    output logic [NUM_TMR-1:0]          tmr_restart,
    output logic [NUM_TMR-1:0]          tmr_tgt_we,
    output logic [NUM_TMR-1:0]          tmr_cnt_rd,
    input  logic [NUM_TMR*TCNT_W-1:0]   tmr_cnt_in
);
    rd_src_e                   rsel;
    logic                      hit_ctl, hit_didx, hit_ddat, hit_port, hit_tgt, hit_tcnt;
    logic [PIDX_W-1:0]         port_idx;
    logic [TIDX_W-1:0]         tgt_idx, cnt_idx;
    logic                      rom_vis;
    logic [DATA_W-1:0]         dsp_idx;
    logic [CLR_GRPS-1:0]       clr_grp;
    logic [NUM_PORTS*DATA_W-1:0] in_bytes;
    logic [DATA_W-1:0]         port_rd, tcnt_rd;

    apuio_decode u_dec (
        .addr(cpu_addr), .rom_vis(rom_vis), .rsel(rsel),
        .hit_ctl(hit_ctl), .hit_didx(hit_didx), .hit_ddat(hit_ddat),
        .hit_port(hit_port), .hit_tgt(hit_tgt), .hit_tcnt(hit_tcnt),
        .port_idx(port_idx), .tgt_idx(tgt_idx), .cnt_idx(cnt_idx)
    );

    apuio_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(cpu_wr && hit_ctl), .idx_we(cpu_wr && hit_didx),
        .wdata(cpu_wdata), .tmr_en(tmr_en), .tmr_restart(tmr_restart),
        .clr_grp(clr_grp), .rom_vis(rom_vis), .dsp_idx(dsp_idx)
    );

    apuio_ports u_ports (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .clr_grp(clr_grp), .out_we(cpu_wr && hit_port), .out_sel(port_idx),
        .cpu_wdata(cpu_wdata), .in_bytes(in_bytes), .out_bytes(host_out)
    );

    // RAM sees every CPU write
    assign ram_we    = cpu_wr;
    assign ram_addr  = cpu_addr;
    assign ram_wdata = cpu_wdata;

    // DSP window: the write is guarded by the top index bit
    assign dsp_addr  = dsp_idx[DSP_AW-1:0];
    assign dsp_wdata = cpu_wdata;
    assign dsp_rd    = cpu_rd && hit_ddat;
    assign dsp_we    = cpu_wr && hit_ddat && !dsp_idx[DSP_AW];

    // Purpose: one-hot timer strobes and the selected port and counter bytes
    always_comb begin
        tmr_tgt_we = '0;
        tmr_cnt_rd = '0;
        tcnt_rd    = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (tgt_idx == TIDX_W'(i)) tmr_tgt_we[i] = cpu_wr && hit_tgt;
            if (cnt_idx == TIDX_W'(i)) begin
                tmr_cnt_rd[i] = cpu_rd && hit_tcnt;
                tcnt_rd       = {{(DATA_W-TCNT_W){1'b0}}, tmr_cnt_in[i*TCNT_W +: TCNT_W]};
            end
        end
        port_rd = '0;
        for (int k = 0; k < NUM_PORTS; k++)
            if (port_idx == PIDX_W'(k)) port_rd = in_bytes[k*DATA_W +: DATA_W];
    end

    // Purpose: CPU read data mux
    always_comb begin
        case (rsel)
            RS_ZERO: cpu_rdata = '0;
            RS_DIDX: cpu_rdata = dsp_idx;
            RS_DDAT: cpu_rdata = dsp_rdata;
            RS_PORT: cpu_rdata = port_rd;
            RS_TCNT: cpu_rdata = tcnt_rd;
            RS_ROM:  cpu_rdata = rom_byte(cpu_addr[ROM_AW-1:0]);
            default: cpu_rdata = ram_rdata;
        endcase
    end

    assert_dsp_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_we |-> (cpu_addr == 16'h00F3) && (dsp_idx < 8'h80));
    assert_strobes_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_tgt_we) && $onehot0(tmr_cnt_rd));
endmodule

// File: tb/apuio_regfile_tb_top.sv
// Scoreboard bench for apuio_regfile. The read driver queues expected bytes
// and a monitor compares them with cpu_rdata one step after the clock edge.
module apuio_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = 8'hEE;
    logic [6:0]  dsp_addr;
    logic        dsp_rd, dsp_we;
    logic [7:0]  dsp_wdata;
    logic [7:0]  dsp_rdata = 8'h6C;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] host_out;
    logic [2:0]  tmr_en, tmr_restart, tmr_tgt_we, tmr_cnt_rd;
    logic [11:0] tmr_cnt_in = 12'h95C;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    apuio_regfile dut_i (.*);

    function automatic logic [7:0] rom_exp(input int i);
        int v;
        v = (((i * 29) + 59) % 256) ^ ((i * 4) % 256);
        return v[7:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Driver: issue a read and queue the expected data for the monitor
    task automatic cpu_read(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Monitor: pop one expected item for each read and compare
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (cpu_rd && exp_q.size() > 0)
                check(tag_q.pop_front(), {24'h0, cpu_rdata}, {24'h0, exp_q.pop_front()});
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 host_out", host_out, 32'h0);
        check("R1 tmr_en", {29'h0, tmr_en}, 32'h0);
        cpu_read(16'h00F2, 8'h00, "R1 dsp index");
        for (int k = 0; k < 4; k++) cpu_read(16'h00F4 + 16'(k), 8'h00, "R1 inbound");
        cpu_read(16'hFFC0, rom_exp(0), "R1 rom visible");

        // R2 zero reads
        cpu_read(16'h00F0, 8'h00, "R2 F0");
        cpu_read(16'h00F1, 8'h00, "R2 F1");
        cpu_read(16'h00FA, 8'h00, "R2 FA");
        cpu_read(16'h00FB, 8'h00, "R2 FB");
        cpu_read(16'h00FC, 8'h00, "R2 FC");

        // R3 DSP index and data window
        cpu_write(16'h00F2, 8'h15);
        cpu_read(16'h00F2, 8'h15, "R3 index readback");
        @(negedge clk);
        cpu_addr = 16'h00F3; cpu_rd = 1'b1;
        exp_q.push_back(8'h6C); tag_q.push_back("R3 data read");
        #1;
        check("R3 dsp_addr", {25'h0, dsp_addr}, 32'h15);
        check("R3 dsp_rd", {31'h0, dsp_rd}, 32'h1);
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_write(16'h00F2, 8'h9A);
        cpu_read(16'h00F2, 8'h9A, "R3 high index readback");
        #1;
        check("R3 masked dsp_addr", {25'h0, dsp_addr}, 32'h1A);

        // R4 guarded DSP write
        @(negedge clk);
        cpu_addr = 16'h00F3; cpu_wdata = 8'h44; cpu_wr = 1'b1;
        #1;
        check("R4 no write at index 9A", {31'h0, dsp_we}, 32'h0);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_write(16'h00F2, 8'h23);
        @(negedge clk);
        cpu_addr = 16'h00F3; cpu_wdata = 8'h44; cpu_wr = 1'b1;
        #1;
        check("R4 write at index 23", {31'h0, dsp_we}, 32'h1);
        check("R4 dsp_wdata", {24'h0, dsp_wdata}, 32'h44);
        check("R4 dsp_addr", {25'h0, dsp_addr}, 32'h23);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R5 mailbox directions
        for (int k = 0; k < 4; k++) host_write(2'(k), 8'hA0 + 8'(k));
        for (int k = 0; k < 4; k++) cpu_read(16'h00F4 + 16'(k), 8'hA0 + 8'(k), "R5 inbound");
        cpu_write(16'h00F5, 8'h77);
        check("R5 outbound byte 1", host_out, 32'h0000_7700);
        cpu_read(16'h00F5, 8'hA1, "R5 no echo");

        // R6 timer enables and restart pulses
        @(negedge clk);
        cpu_addr = 16'h00F1; cpu_wdata = 8'h05; cpu_wr = 1'b1;
        #1;
        check("R6 restart 101", {29'h0, tmr_restart}, 32'h5);
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R6 enables 101", {29'h0, tmr_en}, 32'h5);
        @(negedge clk);
        cpu_addr = 16'h00F1; cpu_wdata = 8'h07; cpu_wr = 1'b1;
        #1;
        check("R6 restart only timer1", {29'h0, tmr_restart}, 32'h2);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_write(16'h00F1, 8'h00);
        check("R6 disabled", {29'h0, tmr_en}, 32'h0);

        // R7 group clears and priority over a host write
        cpu_write(16'h00F1, 8'h10);
        cpu_read(16'h00F4, 8'h00, "R7 clear lo byte0");
        cpu_read(16'h00F5, 8'h00, "R7 clear lo byte1");
        cpu_read(16'h00F6, 8'hA2, "R7 keep byte2");
        cpu_write(16'h00F1, 8'h20);
        cpu_read(16'h00F7, 8'h00, "R7 clear hi byte3");
        host_write(2'd1, 8'h5A);
        @(negedge clk);
        cpu_addr = 16'h00F1; cpu_wdata = 8'h10; cpu_wr = 1'b1;
        host_sel = 2'd1; host_wdata = 8'h55; host_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; host_wr = 1'b0;
        cpu_read(16'h00F5, 8'h00, "R7 clear beats host write");

        // R8 boot ROM overlay
        cpu_read(16'hFFFF, rom_exp(63), "R8 rom last byte");
        cpu_read(16'hFFC5, rom_exp(5), "R8 rom byte 5");
        cpu_read(16'hFFBF, 8'hEE, "R8 below window");
        cpu_write(16'h00F1, 8'h80);
        cpu_read(16'hFFC0, 8'hEE, "R8 rom hidden");
        cpu_write(16'h00F1, 8'h00);
        cpu_read(16'hFFE1, rom_exp(33), "R8 rom shown again");

        // R9 RAM pass-through and target strobes
        @(negedge clk);
        cpu_addr = 16'h00F8; cpu_wdata = 8'h3C; cpu_wr = 1'b1;
        #1;
        check("R9 ram_we", {31'h0, ram_we}, 32'h1);
        check("R9 ram_addr", {16'h0, ram_addr}, 32'h00F8);
        check("R9 ram_wdata", {24'h0, ram_wdata}, 32'h3C);
        @(negedge clk);
        cpu_addr = 16'h00FA; cpu_wdata = 8'h33;
        #1;
        check("R9 target strobe 0", {29'h0, tmr_tgt_we}, 32'h1);
        check("R9 ram_we on I/O", {31'h0, ram_we}, 32'h1);
        @(negedge clk);
        cpu_addr = 16'h00FC;
        #1;
        check("R9 target strobe 2", {29'h0, tmr_tgt_we}, 32'h4);
        @(negedge clk);
        cpu_wr = 1'b0;
        ram_rdata = 8'h71;
        cpu_read(16'h00F9, 8'h71, "R9 F9 is RAM");

        // R10 timer counter reads
        @(negedge clk);
        cpu_addr = 16'h00FD; cpu_rd = 1'b1;
        exp_q.push_back(8'h0C); tag_q.push_back("R10 counter 0");
        #1;
        check("R10 read strobe 0", {29'h0, tmr_cnt_rd}, 32'h1);
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_read(16'h00FF, 8'h09, "R10 counter 2");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule